// File: doc/BRIEF.md
# Page Access Permission Evaluator

This block decides whether one memory access to an already translated page may proceed. It is purely combinational. It takes the protection bits of the page entry, the two storage-key bits of the segment, the page's class key, a data authority mask and an instruction authority mask. From these it computes the read, write and execute rights for the page. Against these rights it checks the requested access, which is an instruction fetch, a load or a store.

The block drives a grant bit. When the access is refused, it also drives a cause vector that a fault unit can copy into an instruction or data fault status. Each source of rights removes only its own kind of access, and the final rights are the intersection of all sources. A page whose changed bit is still clear never reports write rights for a non-store access. This lets a translation cache fill on a read without later missing the first store.

Top module: `pam_access_eval`

## Requirements
- R1: The key used for the protection table is `seg_key_user` when `user_mode` is 1, and `seg_key_super` when `user_mode` is 0.
- R2: The protection code is `{pp_high, pp_low[1:0]}`. With key 0, codes 0, 1 and 2 give read+write+execute, codes 3 and 6 give read+execute, and codes 4, 5 and 7 give nothing.
- R3: With key 1, codes 0, 4, 5, 6 and 7 give nothing, codes 1 and 3 give read+execute, and code 2 gives read+write+execute.
- R4: With the default 5-bit class key k, the data mask field sits at bits [2*(31-k)+1 : 2*(31-k)] of `data_mask`. Its upper bit removes write and its lower bit removes read. Execute is never affected.
- R5: When the instruction-mask option is enabled (the default), bit 2*(31-k) of `inst_mask` removes execute and nothing else. Bit 2*(31-k)+1 of `inst_mask` has no effect.
- R6: `no_exec` or `guarded` removes execute but never read or write.
- R7: When `changed` is 0 and the access is not a store, `rights` has no write bit. A store is unaffected by `changed`.
- R8: `rights` is {read, write, execute} in bits 2, 1, 0. `access` encodes 0 = fetch, 1 = load, 2 = store, and 3 is handled as a load. `grant` is 1 exactly when the needed right (execute, read or write) is in `rights`.
- R9: On a refused fetch, `cause` bit 1 is set if `no_exec` or `guarded` is set. Otherwise bit 0 is set if the table denied execute. Bit 2 is also set if the instruction mask denied execute. Bit 3 stays 0.
- R10: On a refused load or store, `cause` bit 0 is set if the table lacks the needed right. Bit 3 is set for a store. Bit 2 is set if the data mask lacks the needed right.
- R11: When `grant` is 1, `cause` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| user_mode | input | 1 | Access made in problem (user) state |
| seg_key_user | input | 1 | Segment storage key for user state |
| seg_key_super | input | 1 | Segment storage key for privileged state |
| pp_low | input | 2 | Low page protection bits |
| pp_high | input | 1 | High page protection bit (code bit 2) |
| page_key | input | 5 | Page class key (KEY_W) |
| no_exec | input | 1 | Page entry no-execute bit |
| guarded | input | 1 | Page entry guarded bit |
| changed | input | 1 | Page entry changed bit |
| data_mask | input | 64 | Data authority mask, 2 bits per key |
| inst_mask | input | 64 | Instruction authority mask, 2 bits per key |
| access | input | 2 | Requested access type |
| rights | output | 3 | Granted {read, write, execute} |
| grant | output | 1 | Access permitted |
| cause | output | 4 | {store, key mask, no-exec/guard, protection} |

## Verification
The bench walks all eight protection codes under both keys and both privilege states. A design that swapped the two key bits, or copied the key-0 row into key 1, would grant store or read where the table forbids it. The mask tests use the extreme keys 0 and 31 and a middle key. They catch a field taken from the wrong end of the register or with its two bits reversed, which would strip read instead of write. They also catch an instruction mask that wrongly strips read. Fetch denials with guard, table and mask denying together check the guard-over-table precedence and the additive mask cause. Reserved access code 3 and the changed-bit rule on loads and stores are also driven.

// File: rtl/pam_pkg.sv
package pam_pkg;
   typedef enum logic [1:0] {
      ACC_FETCH = 2'd0,
      ACC_LOAD  = 2'd1,
      ACC_STORE = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_e;

   // rights vector bit positions
   localparam int RT_R = 2;
   localparam int RT_W = 1;
   localparam int RT_X = 0;

   // cause vector bit positions
   localparam int CS_PROT  = 0;
   localparam int CS_NXG   = 1;
   localparam int CS_KEY   = 2;
   localparam int CS_STORE = 3;
endpackage

// File: rtl/pam_prot_table.sv
module pam_prot_table
   import pam_pkg::*;
(
   input  logic       key,
   input  logic [2:0] code,
   output logic [2:0] rights
);
   always_comb begin
      rights = 3'b000;
      if (!key) begin
         unique case (code)
            3'd0, 3'd1, 3'd2: rights = 3'b111;
            3'd3, 3'd6:       rights = 3'b101;
            default:          rights = 3'b000;
         endcase
      end else begin
         unique case (code)
            3'd1, 3'd3: rights = 3'b101;
            3'd2:       rights = 3'b111;
            default:    rights = 3'b000;
         endcase
      end
   end
endmodule

// File: rtl/pam_key_mask.sv
module pam_key_mask
   import pam_pkg::*;
#(
   parameter int KEY_W    = 5,
   parameter bit IMASK_EN = 1'b1,
   localparam int NKEYS   = 1 << KEY_W,
   localparam int MASK_W  = 2 * NKEYS
) (
   input  logic [KEY_W-1:0]  key,
   input  logic [MASK_W-1:0] data_mask,
   input  logic [MASK_W-1:0] inst_mask,
   output logic [2:0]        rights
);
   // field position 2*(NKEYS-1-key) equals the inverted key shifted left once
   logic [KEY_W:0] fld_idx;
   logic [1:0]     dfld;
   logic           x_ok;

   assign fld_idx = {~key, 1'b0};
   assign dfld    = data_mask[fld_idx +: 2];

   generate
      if (IMASK_EN) begin : g_imask
         logic [1:0] ifld;
         assign ifld = inst_mask[fld_idx +: 2];
         assign x_ok = ~ifld[0];
      end else begin : g_no_imask
         assign x_ok = 1'b1;
      end
   endgenerate

   always_comb begin
      rights       = 3'b111;
      rights[RT_W] = ~dfld[1];
      rights[RT_R] = ~dfld[0];
      rights[RT_X] = x_ok;
   end
endmodule

// File: rtl/pam_fault_cause.sv
module pam_fault_cause
   import pam_pkg::*;
(
   input  acc_e       acc,
   input  logic       grant,
   input  logic [2:0] tbl_rights,
   input  logic [2:0] msk_rights,
   input  logic       nxg_deny,
   output logic [3:0] cause
);
   int unsigned need;

   always_comb begin
      cause = 4'b0000;
      need  = (acc == ACC_STORE) ? RT_W : RT_R;
      if (!grant) begin
         if (acc == ACC_FETCH) begin
            if (nxg_deny)               cause[CS_NXG]  = 1'b1;
            else if (!tbl_rights[RT_X]) cause[CS_PROT] = 1'b1;
            if (!msk_rights[RT_X])      cause[CS_KEY]  = 1'b1;
         end else begin
            if (!tbl_rights[need])      cause[CS_PROT]  = 1'b1;
            if (acc == ACC_STORE)       cause[CS_STORE] = 1'b1;
            if (!msk_rights[need])      cause[CS_KEY]   = 1'b1;
         end
      end
   end
endmodule

// File: rtl/pam_access_eval.sv
module pam_access_eval
   import pam_pkg::*;
#(
   parameter int KEY_W    = 5,
   parameter bit IMASK_EN = 1'b1,
   localparam int NKEYS   = 1 << KEY_W,
   localparam int MASK_W  = 2 * NKEYS
) (
   input  logic              user_mode,
   input  logic              seg_key_user,
   input  logic              seg_key_super,
   input  logic [1:0]        pp_low,
   input  logic              pp_high,
   input  logic [KEY_W-1:0]  page_key,
   input  logic              no_exec,
   input  logic              guarded,
   input  logic              changed,
   input  logic [MASK_W-1:0] data_mask,
   input  logic [MASK_W-1:0] inst_mask,
   input  logic [1:0]        access,
   output logic [2:0]        rights,
   output logic              grant,
   output logic [3:0]        cause
);
   generate
      if (KEY_W < 1 || KEY_W > 6) begin : g_bad_key_w
         $error("pam_access_eval: KEY_W must lie in 1..6");
      end
   endgenerate

   acc_e       acc;
   logic       eff_key;
   logic [2:0] tbl_rights;
   logic [2:0] msk_rights;
   logic       nxg_deny;
   logic [2:0] all_rights;

   assign acc      = acc_e'(access);
   assign eff_key  = user_mode ? seg_key_user : seg_key_super;
   assign nxg_deny = no_exec | guarded;

   pam_prot_table u_table (
      .key    (eff_key),
      .code   ({pp_high, pp_low}),
      .rights (tbl_rights)
   );

   pam_key_mask #(
      .KEY_W    (KEY_W),
      .IMASK_EN (IMASK_EN)
   ) u_mask (
      .key       (page_key),
      .data_mask (data_mask),
      .inst_mask (inst_mask),
      .rights    (msk_rights)
   );

   always_comb begin
      all_rights = tbl_rights & msk_rights & {2'b11, ~nxg_deny};
      rights     = all_rights;
      if (!changed && acc != ACC_STORE) rights[RT_W] = 1'b0;
      unique case (acc)
         ACC_FETCH: grant = rights[RT_X];
         ACC_STORE: grant = rights[RT_W];
         default:   grant = rights[RT_R];
      endcase
   end

   pam_fault_cause u_cause (
      .acc        (acc),
      .grant      (grant),
      .tbl_rights (tbl_rights),
      .msk_rights (msk_rights),
      .nxg_deny   (nxg_deny),
      .cause      (cause)
   );
endmodule

module pam_access_eval_chk #(
   parameter int KEY_W    = 5,
   parameter bit IMASK_EN = 1'b1,
   localparam int NKEYS   = 1 << KEY_W,
   localparam int MASK_W  = 2 * NKEYS
) (
   input logic [KEY_W-1:0]  page_key,
   input logic              no_exec,
   input logic              guarded,
   input logic              changed,
   input logic [MASK_W-1:0] data_mask,
   input logic [MASK_W-1:0] inst_mask,
   input logic [1:0]        access,
   input logic [2:0]        rights,
   input logic              grant,
   input logic [3:0]        cause
);
   int unsigned idx;
   assign idx = 2 * (NKEYS - 1 - int'(page_key));

   always_comb begin
      a_r6_guard_no_exec: assert (!(no_exec || guarded) || !rights[0])
         else $error("R6: execute granted on no-exec/guarded page");
      a_r7_clean_no_write: assert (changed || access == 2'd2 || !rights[1])
         else $error("R7: write reported on clean page for non-store");
      a_r4_dmask_write: assert (!data_mask[idx+1] || !rights[1])
         else $error("R4: data mask write bit ignored");
      a_r4_dmask_read: assert (!data_mask[idx] || !rights[2])
         else $error("R4: data mask read bit ignored");
      if (IMASK_EN) begin
         a_r5_imask_exec: assert (!inst_mask[idx] || !rights[0])
            else $error("R5: instruction mask bit ignored");
      end
      a_r8_grant_right: assert (!grant ||
            (access == 2'd0 ? rights[0] : access == 2'd2 ? rights[1] : rights[2]))
         else $error("R8: grant without the needed right");
      a_r11_grant_no_cause: assert (!grant || cause == 4'b0000)
         else $error("R11: cause reported on granted access");
      a_r10_store_flag: assert (grant || access != 2'd2 || cause[3])
         else $error("R10: refused store lacks store flag");
      a_r9_fetch_cause: assert (grant || access != 2'd0 ||
            (cause[2:0] != 3'b000 && !cause[3]))
         else $error("R9: refused fetch has bad cause");
   end
endmodule

bind pam_access_eval pam_access_eval_chk #(
   .KEY_W    (KEY_W),
   .IMASK_EN (IMASK_EN)
) u_chk (
   .page_key  (page_key),
   .no_exec   (no_exec),
   .guarded   (guarded),
   .changed   (changed),
   .data_mask (data_mask),
   .inst_mask (inst_mask),
   .access    (access),
   .rights    (rights),
   .grant     (grant),
   .cause     (cause)
);

// File: tb/pam_access_eval_tb.sv
module pam_access_eval_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        user_mode, seg_key_user, seg_key_super;
   logic [1:0]  pp_low;
   logic        pp_high;
   logic [4:0]  page_key;
   logic        no_exec, guarded, changed;
   logic [63:0] data_mask, inst_mask;
   logic [1:0]  access;
   logic [2:0]  rights;
   logic        grant;
   logic [3:0]  cause;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pam_access_eval dut_i (
      .user_mode     (user_mode),
      .seg_key_user  (seg_key_user),
      .seg_key_super (seg_key_super),
      .pp_low        (pp_low),
      .pp_high       (pp_high),
      .page_key      (page_key),
      .no_exec       (no_exec),
      .guarded       (guarded),
      .changed       (changed),
      .data_mask     (data_mask),
      .inst_mask     (inst_mask),
      .access        (access),
      .rights        (rights),
      .grant         (grant),
      .cause         (cause)
   );

   // expected values written from the requirement tables
   function automatic logic [2:0] tbl_ref(input logic k, input logic [2:0] c);
      if (!k) return (c <= 3'd2) ? 3'b111 : (c == 3'd3 || c == 3'd6) ? 3'b101 : 3'b000;
      return (c == 3'd2) ? 3'b111 : (c == 3'd1 || c == 3'd3) ? 3'b101 : 3'b000;
   endfunction

   task automatic model(output logic [2:0] er, output logic eg, output logic [3:0] ec);
      logic       k;
      logic [2:0] t, m;
      logic       gx;
      int         pos, nd;
      k   = user_mode ? seg_key_user : seg_key_super;
      t   = tbl_ref(k, {pp_high, pp_low});
      pos = 2 * (31 - int'(page_key));
      m   = {~data_mask[pos], ~data_mask[pos+1], ~inst_mask[pos]};
      gx  = ~(no_exec | guarded);
      er  = t & m & {2'b11, gx};
      if (!changed && access != 2'd2) er[1] = 1'b0;
      nd  = (access == 2'd0) ? 0 : (access == 2'd2) ? 1 : 2;
      eg  = er[nd];
      ec  = 4'b0000;
      if (!eg) begin
         if (access == 2'd0) begin
            if (!gx) ec[1] = 1'b1;
            else if (!t[0]) ec[0] = 1'b1;
            if (!m[0]) ec[2] = 1'b1;
         end else begin
            if (!t[nd]) ec[0] = 1'b1;
            if (access == 2'd2) ec[3] = 1'b1;
            if (!m[nd]) ec[2] = 1'b1;
         end
      end
   endtask

   task automatic apply_check(input string req);
      logic [2:0] er;
      logic eg;
      logic [3:0] ec;
      @(negedge clk);
      model(er, eg, ec);
      checks++;
      if (rights !== er || grant !== eg || cause !== ec) begin
         errors++;
         $display("FAIL %s: rights=%b grant=%b cause=%b expected rights=%b grant=%b cause=%b",
                  req, rights, grant, cause, er, eg, ec);
      end
      @(posedge clk);
   endtask

   task automatic set_defaults();
      user_mode = 0; seg_key_user = 0; seg_key_super = 0;
      pp_low = 0; pp_high = 0; page_key = 0;
      no_exec = 0; guarded = 0; changed = 0;
      data_mask = '0; inst_mask = '0; access = 2'd1;
   endtask

   task automatic t_idle();
      set_defaults();
      apply_check("R8 idle load, R7 no write on clean page");
   endtask

   task automatic t_table();
      set_defaults();
      changed = 1;
      for (int um = 0; um < 2; um++)
         for (int ks = 0; ks < 2; ks++)
            for (int c = 0; c < 8; c++)
               for (int a = 0; a < 3; a++) begin
                  user_mode = um[0]; seg_key_user = ks[0]; seg_key_super = ~ks[0];
                  {pp_high, pp_low} = c[2:0]; access = a[1:0];
                  apply_check((ks == um) ? "R1 R3 key1 table" : "R1 R2 key0 table");
               end
   endtask

   task automatic t_data_mask();
      int keys[3] = '{0, 17, 31};
      set_defaults();
      changed = 1;
      foreach (keys[i]) begin
         page_key = keys[i][4:0];
         for (int f = 1; f < 4; f++)
            for (int a = 0; a < 3; a++) begin
               data_mask = '0;
               data_mask[2*(31-keys[i]) +: 2] = f[1:0];
               data_mask[2*(31-((keys[i]+1)%32)) +: 2] = 2'b11; // neighbour key
               access = a[1:0];
               apply_check("R4 R10 data mask field");
            end
      end
   endtask

   task automatic t_inst_mask();
      int keys[3] = '{0, 9, 31};
      set_defaults();
      changed = 1;
      foreach (keys[i]) begin
         page_key = keys[i][4:0];
         for (int f = 1; f < 4; f++)
            for (int a = 0; a < 3; a++) begin
               inst_mask = '0;
               inst_mask[2*(31-keys[i]) +: 2] = f[1:0];
               access = a[1:0];
               apply_check("R5 R9 instruction mask field");
            end
      end
   endtask

   task automatic t_guard();
      set_defaults();
      changed = 1;
      for (int g = 1; g < 4; g++)
         for (int a = 0; a < 3; a++) begin
            {no_exec, guarded} = g[1:0]; access = a[1:0];
            apply_check("R6 no-exec/guard removes execute only");
         end
   endtask

   task automatic t_fetch_cause();
      set_defaults();
      access = 2'd0; changed = 1;
      // guard plus table denial: guard cause wins over protection
      pp_high = 1; pp_low = 2'b00; guarded = 1;
      apply_check("R9 guard over table");
      guarded = 0;
      apply_check("R9 table denial");
      inst_mask[2*31] = 1'b1;
      apply_check("R9 table plus mask");
      pp_high = 0;
      apply_check("R9 mask only");
      no_exec = 1;
      apply_check("R9 guard plus mask");
   endtask

   task automatic t_changed_and_rsvd();
      set_defaults();
      changed = 0; access = 2'd2;
      apply_check("R7 store on clean page");
      access = 2'd3;
      apply_check("R8 code 3 as load");
      data_mask[2*31] = 1'b1;
      apply_check("R8 R10 code 3 load denial");
      changed = 1;
      apply_check("R7 changed page load");
      access = 2'd3; data_mask = '0; seg_key_super = 1; pp_low = 2'b00;
      apply_check("R10 R3 code 3 table denial");
      access = 2'd2; pp_low = 2'b01;
      apply_check("R10 R11 store denied read-only");
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      set_defaults();
      @(posedge clk);
      t_idle();
      t_table();
      t_data_mask();
      t_inst_mask();
      t_guard();
      t_fetch_cause();
      t_changed_and_rsvd();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule